// File: doc/BRIEF.md
# Strap-Addressed SMBus Register Target

This block is the serial-bus target front end of a system-monitoring device. It watches the two bus lines, synchronizes them into the system clock domain, and detects start and stop conditions. It then answers transactions aimed at its own 7-bit address, and turns them into single-cycle strobes on a plain register port that the device's register file serves. The data line is open drain. The block only ever pulls it low, through `sda_oe`.

The upper five address bits are a fixed prefix, 01011. The lower two bits come from a three-state strap pin. The analog part of that pin lies outside this block and reports its state as two sense bits. The strap is captured once, in the first clock after reset is released, and is then held until the next reset. A write transaction first loads a register pointer and then writes data bytes to the pointed register. A repeated start followed by a read address returns the pointed register, one byte per master acknowledge. If the clock line stays low for too long, the protocol engine drops back to idle and releases the data line.

Top module: `smb_strap_target`

## Requirements
- R1: The target address is {01011, XY}. The strap sense bits decode to XY as follows: `strap_low` alone gives 10, `strap_high` alone gives 01, and neither or both give 00. XY is never 11, so the address 0101111 is never acknowledged.
- R2: XY is taken from the strap inputs in the first clock after `rst_n` rises. Later strap changes do not alter the acknowledged address until the next reset.
- R3: An address byte whose upper seven bits match the target address is acknowledged by pulling SDA low during the ninth clock. Any other address is left unacknowledged. The bytes that follow in that transaction are also left unacknowledged and produce no register strobe.
- R4: The first data byte after an acknowledged write address is acknowledged and stored as the register pointer. It produces no write strobe.
- R5: Each later data byte of a write is acknowledged and produces a one-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: After an acknowledged read address, `reg_re` pulses once with `reg_addr` equal to the pointer. The returned byte is then shifted out MSB first, with each bit changed after an SCL falling edge. `reg_we` and `reg_re` are never high together.
- R7: After a read byte, a master acknowledge (SDA low in the ninth clock) causes one more `reg_re` and another copy of the pointed register. A master non-acknowledge releases SDA and causes no further read strobe.
- R8: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start, including a repeated start in the middle of a byte, begins a new address phase. A stop returns the block to idle with SDA released.
- R9: If SCL stays low for `TIMEOUT_CYC` consecutive system clocks, the block returns to idle and releases SDA, even in the middle of a read. The next transaction is then served normally.
- R10: While in reset and right after it, `sda_oe`, `reg_we` and `reg_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_low | input | 1 | Strap pin sensed tied to ground |
| strap_high | input | 1 | Strap pin sensed tied to supply |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle `reg_re` is high |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
Every bus input passes two synchronizer flops and an edge register before the state register acts on it. So `sda_oe`, `reg_we` and `reg_re` change on the third system clock edge after the SCL edge that caused them, and the read byte is captured one edge after `reg_re`. The bench holds every SCL phase for twelve system clocks and samples SDA, and so the acknowledge and read bits, at the end of the high phase, well past that three-edge latency. It logs the strobes at falling clock edges. The timeout is checked twice against `TIMEOUT_CYC`: once well before the limit, when the target must still be driving, and once well after it, when SDA must be free.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WACK,
    ST_WBYTE,
    ST_RACK_A,
    ST_RBYTE,
    ST_MACK,
    ST_SKIP
  } phase_e;

  // strap sense -> low address pair; conflicting sense falls back to 00
  function automatic logic [1:0] strap_xy(input logic lo, input logic hi);
    case ({lo, hi})
      2'b10:   return 2'b10;
      2'b01:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [6:0] own_addr(input logic [4:0] prefix, input logic [1:0] xy);
    return {prefix, xy};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] synced;
  logic             scl_q, sda_q;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s = synced[0];
  assign sda_s = synced[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_evt =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_evt  =  scl_s &  scl_q & ~sda_q &  sda_s;

  AST_START_STOP_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt)); // R8
  AST_COND_NEEDS_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> $past(scl_s)); // R8

endmodule

// File: rtl/smb_strap_latch.sv
module smb_strap_latch
  import smb_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_low,
  input  logic       strap_high,
  output logic [1:0] xy,
  output logic       done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xy   <= 2'b00;
      done <= 1'b0;
    end else if (!done) begin
      xy   <= strap_xy(strap_low, strap_high);
      done <= 1'b1;
    end
  end

  AST_XY_NEVER_ELEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (xy != 2'b11)); // R1
  AST_XY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> $stable(xy)); // R2

endmodule

// File: rtl/smb_low_timeout.sv
module smb_low_timeout #(
  parameter int LIMIT = 1750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  output logic timeout_pulse
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       low_cnt <= '0;
    else if (scl_s)                   low_cnt <= '0;
    else if (low_cnt != CW'(LIMIT))   low_cnt <= low_cnt + 1'b1;
  end

  assign timeout_pulse = !scl_s && (low_cnt == CW'(LIMIT - 1));

  AST_TIMEOUT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> ($past(!scl_s) && !scl_s)); // R9
  AST_TIMEOUT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse); // R9

endmodule

// File: rtl/smb_strap_target.sv
module smb_strap_target
  import smb_tgt_pkg::*;
#(
  parameter int         TIMEOUT_CYC = 1750000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       strap_low,
  input  logic       strap_high,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       reg_re
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic timeout_evt;
  logic [1:0] strap_val;
  logic strap_done;
  logic [6:0] my_addr;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_strap_latch u_strap (
    .clk(clk), .rst_n(rst_n), .strap_low(strap_low), .strap_high(strap_high),
    .xy(strap_val), .done(strap_done)
  );

  smb_low_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .timeout_pulse(timeout_evt)
  );

  assign my_addr = own_addr(ADDR_PREFIX, strap_val);

  phase_e            state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, ptr, wdata_q;
  logic              ptr_next, m_ack, oe_q, we_q, re_q;

  // named internal events for the checks
  logic byte_in_done, addr_hit, bus_reset;
  assign byte_in_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
  assign addr_hit     = strap_done && (rx_sh[7:1] == my_addr);
  assign bus_reset    = timeout_evt || stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      wdata_q  <= '0;
      ptr_next <= 1'b0;
      m_ack    <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (re_q) tx_sh <= reg_rdata;
      if (bus_reset) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_in_done) begin
              if (addr_hit) begin
                oe_q <= 1'b1;
                if (rx_sh[0]) begin
                  state <= ST_RACK_A;
                  re_q  <= 1'b1;
                end else begin
                  state    <= ST_WACK;
                  ptr_next <= 1'b1;
                end
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state   <= ST_WBYTE;
              bit_cnt <= '0;
            end
          end
          ST_WBYTE: begin
            if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_in_done) begin
              oe_q  <= 1'b1;
              state <= ST_WACK;
              if (ptr_next) begin
                ptr      <= rx_sh;
                ptr_next <= 1'b0;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= rx_sh;
              end
            end
          end
          ST_RACK_A: begin
            if (scl_fall) begin
              state   <= ST_RBYTE;
              bit_cnt <= '0;
              oe_q    <= ~tx_sh[BYTE_W-1];
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                oe_q  <= 1'b0;
                state <= ST_MACK;
              end else begin
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                oe_q    <= ~tx_sh[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
              if (!sda_s) re_q <= 1'b1;
            end else if (scl_fall) begin
              if (m_ack) begin
                state   <= ST_RBYTE;
                bit_cnt <= '0;
                oe_q    <= ~tx_sh[BYTE_W-1];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;

  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R5
  AST_WE_RE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re)); // R6
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe); // R8
  AST_TIMEOUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (!sda_oe && state == ST_IDLE)); // R9
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !bus_reset) |=> (state == ST_ADDR)); // R8
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!sda_oe && !reg_we)); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R10

endmodule

// File: tb/smb_strap_target_tb.sv
module smb_strap_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam int TO_CYC     = 200;
  localparam int WD_CYC     = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_low = 1'b0, strap_high = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [256];

  int total = 0, bad = 0, we_cnt = 0, re_cnt = 0;
  int last_wa = -1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  smb_strap_target #(.TIMEOUT_CYC(TO_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_low(strap_low), .strap_high(strap_high),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  always @(negedge clk) begin
    if (reg_we) begin
      mem[reg_addr] = reg_wdata;
      we_cnt++;
      last_wa = int'(reg_addr);
    end
    if (reg_re) re_cnt++;
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic lo, logic hi);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    strap_low = lo; strap_high = hi;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_clk(HALF);
      scl_m = 1'b1; wait_clk(HALF);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    acked = !sda_line;
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HALF);
      scl_m = 1'b1; wait_clk(HALF);
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    sda_m = !give_ack; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b1;
  endtask

  task automatic probe(logic [6:0] a, bit exp_ack, string req);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == exp_ack, req, $sformatf("ack for address %0h", a), ack, exp_ack);
    bus_stop();
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b1);
    chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0 && reg_re == 1'b0, "R10", "strobes after reset", {reg_we, reg_re}, 0);
  endtask

  task automatic t_addr_match();
    bit ack;
    int we0;
    probe(7'h2D, 1'b1, "R1");
    probe(7'h2F, 1'b0, "R1");
    we0 = we_cnt;
    bus_start();
    send_byte({7'h2E, 1'b0}, ack);
    chk(!ack, "R3", "foreign address", ack, 0);
    send_byte(8'h40, ack);
    chk(!ack, "R3", "byte after foreign address", ack, 0);
    send_byte(8'h77, ack);
    chk(!ack, "R3", "second byte after foreign address", ack, 0);
    bus_stop();
    chk(we_cnt == we0, "R3", "write strobes after NACK", we_cnt, we0);
  endtask

  task automatic t_write();
    bit ack;
    int we0;
    we0 = we_cnt;
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    send_byte(8'h10, ack);
    chk(ack, "R4", "pointer byte ack", ack, 1);
    chk(we_cnt == we0, "R4", "no strobe on pointer", we_cnt, we0);
    send_byte(8'hA5, ack);
    chk(ack, "R5", "data byte ack", ack, 1);
    chk(we_cnt == we0 + 1 && last_wa == 'h10 && mem[8'h10] == 8'hA5, "R5",
        "first write", {last_wa[7:0], mem[8'h10]}, 16'h10A5);
    send_byte(8'h3C, ack);
    chk(we_cnt == we0 + 2 && mem[8'h10] == 8'h3C, "R5", "second write", mem[8'h10], 8'h3C);
    bus_stop();
  endtask

  task automatic t_read();
    bit ack;
    logic [7:0] b;
    int re0;
    mem[8'h10] = 8'h96;
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    send_byte(8'h10, ack);
    re0 = re_cnt;
    bus_start();
    send_byte({7'h2D, 1'b1}, ack);
    chk(ack, "R6", "read address ack", ack, 1);
    chk(re_cnt == re0 + 1, "R6", "read strobe count", re_cnt, re0 + 1);
    recv_byte(b, 1'b1);
    chk(b == 8'h96, "R6", "first read byte", b, 8'h96);
    chk(re_cnt == re0 + 2, "R7", "strobe after master ack", re_cnt, re0 + 2);
    recv_byte(b, 1'b0);
    chk(b == 8'h96, "R7", "second read byte", b, 8'h96);
    chk(re_cnt == re0 + 2, "R7", "no strobe after master nack", re_cnt, re0 + 2);
    chk(sda_oe == 1'b0, "R7", "sda released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_restart_mid_byte();
    bit ack;
    logic [7:0] b;
    int we0;
    mem[8'h20] = 8'h5A;
    we0 = we_cnt;
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    send_byte(8'h20, ack);
    send_bits(8'hE0, 3);
    bus_start();
    send_byte({7'h2D, 1'b1}, ack);
    chk(ack, "R8", "address after mid-byte restart", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == 8'h5A, "R8", "read after restart", b, 8'h5A);
    bus_stop();
    chk(sda_oe == 1'b0 && we_cnt == we0, "R8", "idle after stop", {sda_oe, 8'(we_cnt - we0)}, 0);
  endtask

  task automatic t_strap_frozen();
    strap_high = 1'b0; strap_low = 1'b1;
    wait_clk(4);
    probe(7'h2D, 1'b1, "R2");
    probe(7'h2E, 1'b0, "R2");
  endtask

  task automatic t_strap_variants();
    do_reset(1'b1, 1'b0);
    probe(7'h2E, 1'b1, "R1");
    probe(7'h2D, 1'b0, "R1");
    do_reset(1'b0, 1'b0);
    probe(7'h2C, 1'b1, "R1");
    probe(7'h2F, 1'b0, "R1");
    do_reset(1'b1, 1'b1);
    probe(7'h2C, 1'b1, "R1");
    probe(7'h2F, 1'b0, "R1");
  endtask

  task automatic t_timeout();
    bit ack;
    do_reset(1'b0, 1'b1);
    mem[8'h30] = 8'h00;
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    send_byte(8'h30, ack);
    bus_start();
    send_byte({7'h2D, 1'b1}, ack);
    wait_clk(TO_CYC / 2);
    chk(sda_oe == 1'b1, "R9", "still driving before limit", sda_oe, 1);
    wait_clk(TO_CYC);
    chk(sda_oe == 1'b0, "R9", "released after timeout", sda_oe, 0);
    scl_m = 1'b1;
    wait_clk(HALF);
    probe(7'h2D, 1'b1, "R9");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset_state();
    t_addr_match();
    t_write();
    t_read();
    t_restart_mid_byte();
    t_strap_frozen();
    t_strap_variants();
    t_timeout();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=done", WD_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule